// File: doc/BRIEF.md
# Segmented Address Register Unit

This block holds the memory address used by a small 8-bit CPU datapath. The 16-bit address is kept as two bytes, each written from the 8-bit data bus under its own strobe. A third register, the segment, supplies the address bits above bit 15. The three registers are concatenated into one wide physical address, so most code works with 16-bit addresses while a rarely changed segment value selects a larger window of memory.

A zero-page strobe writes the low byte from the data bus and clears the high byte in the same clock. An access to the first 256 locations of the current segment therefore needs one load cycle instead of two. The segment width is a parameter from 1 to 8 bits. This gives a physical address of 17 bits (128K) up to 24 bits (16M locations at 8 bits each; the default).

The high byte is steered by a small decoder that picks one of three named actions each cycle. `HI_HOLD` keeps the value. `HI_LOAD` takes the data bus. `HI_ZERO` clears it. The decoder moves from any action to any other on every clock, based only on the current strobes. All registers update on the rising clock edge, and the address output comes straight from the registers.

Top module: `seg_addr_unit`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the high byte, the low byte and the segment all become zero, so `phys_addr` reads 0 after that edge.
- R2: With only `ld_lo` asserted, the low byte (`phys_addr[7:0]`) takes `data_in` on the next edge, and the high byte and segment keep their values.
- R3: With only `ld_hi` asserted, the high byte (`phys_addr[15:8]`) takes `data_in` on the next edge, and the low byte and segment keep their values.
- R4: With `ld_lo` and `ld_hi` both asserted and `ld_zp` low, both bytes take the same `data_in` value on the next edge.
- R5: With `ld_zp` asserted, the low byte takes `data_in` and the high byte becomes 0 on the same edge, whatever the state of `ld_lo`.
- R6: When `ld_zp` and `ld_hi` are asserted together, the high byte is cleared to 0, not loaded.
- R7: With `ld_seg` asserted, the segment (`phys_addr[PA_W-1:16]`) takes `data_in[SEG_W-1:0]` on the next edge. This does not depend on any byte strobe and can happen in the same cycle as one.
- R8: With no strobe asserted and `rst` low, `phys_addr` does not change across the edge.
- R9: `phys_addr` is {segment, high byte, low byte} and is `PA_W = 16 + SEG_W` bits wide, with `SEG_W` from 1 to 8.
- R10: `rst` takes priority over every strobe asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Data bus value to be loaded |
| ld_lo | input | 1 | Load low address byte |
| ld_hi | input | 1 | Load high address byte |
| ld_zp | input | 1 | Zero-page load: low byte from bus, high byte cleared |
| ld_seg | input | 1 | Load segment from the low SEG_W bits of the bus |
| phys_addr | output | PA_W | Physical address {segment, high, low} |

## Verification
The bench steps through all sixteen combinations of the four strobes under changing data, and it sweeps the zero-page load over all 256 bus values. Before each zero-page load it writes a non-zero high byte, so a design that loaded the high byte, or held it, leaves a stale page visible. Combining the zero-page strobe with the high-byte strobe catches a priority mix-up, which would load the bus into the high byte. A reset asserted together with every strobe catches a reset that loses to a load. The segment is checked alongside byte loads, which exposes swapped or truncated concatenation fields.

// File: rtl/adr_pkg.sv
package adr_pkg;

    // Action applied to the high address byte in one cycle
    typedef enum logic [1:0] {
        HI_HOLD = 2'd0,
        HI_LOAD = 2'd1,
        HI_ZERO = 2'd2
    } hi_op_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OFS_W  = 2 * BYTE_W;

endpackage

// File: rtl/adr_ctl.sv
module adr_ctl
    import adr_pkg::*;
(
    input  logic   ld_lo,
    input  logic   ld_hi,
    input  logic   ld_zp,
    output logic   lo_we,
    output hi_op_e hi_op
);

    // Low byte is written by either its own strobe or the zero-page strobe
    always_comb begin
        lo_we = ld_lo | ld_zp;
    end

    // High byte action: zero-page clear outranks a plain load
    always_comb begin
        unique case ({ld_zp, ld_hi})
            2'b00:   hi_op = HI_HOLD;
            2'b01:   hi_op = HI_LOAD;
            2'b10,
            2'b11:   hi_op = HI_ZERO;
            default: hi_op = HI_HOLD;
        endcase
    end

endmodule

// File: rtl/adr_byte_reg.sv
module adr_byte_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q_r <= '0;
        end else if (we) begin
            q_r <= d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import adr_pkg::*;
#(
    parameter int unsigned SEG_W = 8,
    localparam int unsigned PA_W = OFS_W + SEG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      data_in,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic            ld_zp,
    input  logic            ld_seg,
    output logic [PA_W-1:0] phys_addr
);

    logic         lo_we;
    hi_op_e       hi_op;
    logic [7:0]   lo_q;
    logic [7:0]   hi_q;
    logic [SEG_W-1:0] seg_q;
    logic         hi_we;
    logic         hi_clr;

    adr_ctl u_ctl (
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .ld_zp (ld_zp),
        .lo_we (lo_we),
        .hi_op (hi_op)
    );

    // Output process for the high-byte action decoder
    always_comb begin
        hi_we  = 1'b0;
        hi_clr = 1'b0;
        unique case (hi_op)
            HI_HOLD: ;
            HI_LOAD: hi_we  = 1'b1;
            HI_ZERO: hi_clr = 1'b1;
            default: ;
        endcase
    end

    adr_byte_reg #(.W(BYTE_W)) u_lo (
        .clk (clk),
        .rst (rst),
        .we  (lo_we),
        .clr (1'b0),
        .d   (data_in),
        .q   (lo_q)
    );

    adr_byte_reg #(.W(BYTE_W)) u_hi (
        .clk (clk),
        .rst (rst),
        .we  (hi_we),
        .clr (hi_clr),
        .d   (data_in),
        .q   (hi_q)
    );

    adr_byte_reg #(.W(SEG_W)) u_seg (
        .clk (clk),
        .rst (rst),
        .we  (ld_seg),
        .clr (1'b0),
        .d   (data_in[SEG_W-1:0]),
        .q   (seg_q)
    );

    assign phys_addr = {seg_q, hi_q, lo_q};

    // R9 segment width must give at least 17 and at most 24 address bits
    initial begin
        seg_width_chk: assert (SEG_W >= 1 && SEG_W <= 8)
            else $error("SEG_W out of range");
    end

    // R1 R10
    property p_reset;
        @(posedge clk) rst |=> (phys_addr == '0);
    endproperty
    reset_clear_chk: assert property (p_reset);

    // R5 R6
    property p_zp_page;
        @(posedge clk) disable iff (rst)
            ld_zp |=> (phys_addr[15:8] == 8'h00) && (phys_addr[7:0] == $past(data_in));
    endproperty
    zp_page_chk: assert property (p_zp_page);

    // R7
    property p_seg_load;
        @(posedge clk) disable iff (rst)
            ld_seg |=> (phys_addr[PA_W-1:16] == $past(data_in[SEG_W-1:0]));
    endproperty
    seg_load_chk: assert property (p_seg_load);

    // R8
    property p_hold;
        @(posedge clk) disable iff (rst)
            !(ld_lo || ld_hi || ld_zp || ld_seg) |=> $stable(phys_addr);
    endproperty
    idle_hold_chk: assert property (p_hold);

    // R3
    property p_hi_only;
        @(posedge clk) disable iff (rst)
            (ld_hi && !ld_zp && !ld_lo) |=>
                (phys_addr[15:8] == $past(data_in)) && $stable(phys_addr[7:0]);
    endproperty
    hi_only_chk: assert property (p_hi_only);

    // R2
    property p_lo_only;
        @(posedge clk) disable iff (rst)
            (ld_lo && !ld_zp && !ld_hi) |=>
                (phys_addr[7:0] == $past(data_in)) && $stable(phys_addr[15:8]);
    endproperty
    lo_only_chk: assert property (p_lo_only);

endmodule

// File: tb/seg_addr_unit_bench.sv
module seg_addr_unit_bench;

    localparam int SEG_W = 8;
    localparam int PA_W  = 16 + SEG_W;

    logic            clk = 1'b0;
    logic            rst;
    logic [7:0]      data_in;
    logic            ld_lo, ld_hi, ld_zp, ld_seg;
    logic [PA_W-1:0] phys_addr;

    int total = 0;
    int bad   = 0;

    logic [7:0]       m_lo, m_hi;
    logic [SEG_W-1:0] m_seg;

    always #5 clk = ~clk;

    seg_addr_unit #(.SEG_W(SEG_W)) u_seg_addr_unit (
        .clk       (clk),
        .rst       (rst),
        .data_in   (data_in),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .ld_zp     (ld_zp),
        .ld_seg    (ld_seg),
        .phys_addr (phys_addr)
    );

    task automatic check(input string tag, input logic [PA_W-1:0] exp);
        total++;
        if (phys_addr !== exp) begin
            bad++;
            $display("FAIL %s: phys_addr=%h expected=%h", tag, phys_addr, exp);
        end
    endtask

    // Drive on falling edge, model update per requirements, compare after rise
    task automatic step(input logic r, input logic [3:0] ctl, input logic [7:0] d,
                        input string tag);
        @(negedge clk);
        rst = r; ld_zp = ctl[3]; ld_seg = ctl[2]; ld_hi = ctl[1]; ld_lo = ctl[0];
        data_in = d;
        if (r) begin
            m_lo = '0; m_hi = '0; m_seg = '0;
        end else begin
            if (ctl[3] || ctl[0]) m_lo = d;
            if (ctl[3])           m_hi = 8'h00;
            else if (ctl[1])      m_hi = d;
            if (ctl[2])           m_seg = d[SEG_W-1:0];
        end
        @(posedge clk);
        #1;
        check(tag, {m_seg, m_hi, m_lo});
    endtask

    function automatic string tag_of(input logic [3:0] c);
        if (c[3] && c[1]) return "R6";
        if (c[3])         return "R5";
        if (c[1] && c[0]) return "R4";
        if (c[1])         return "R3";
        if (c[0])         return "R2";
        if (c[2])         return "R7";
        return "R8";
    endfunction

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; data_in = 8'h00;
        ld_lo = 1'b0; ld_hi = 1'b0; ld_zp = 1'b0; ld_seg = 1'b0;
        m_lo = 'x; m_hi = 'x; m_seg = 'x;

        // R1 reset state
        step(1'b1, 4'b0000, 8'h5A, "R1");
        step(1'b1, 4'b0000, 8'hC3, "R1");

        // R9 field placement: distinct values in each field
        step(1'b0, 4'b0100, 8'hA5, "R9");
        step(1'b0, 4'b0010, 8'h3C, "R9");
        step(1'b0, 4'b0001, 8'h81, "R9");

        // Sweep of all strobe combinations with varying data
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b0, 4'(c), 8'((c * 37 + i * 91 + 13) & 255), tag_of(4'(c)));
            end
        end

        // R5 zero-page over all bus values, high byte primed non-zero first
        for (int v = 0; v < 256; v++) begin
            step(1'b0, 4'b0010, 8'(~v | 8'h01), "R3");
            step(1'b0, 4'b1000, 8'(v), "R5");
        end

        // R6 zero-page with high-byte strobe, and with both byte strobes
        step(1'b0, 4'b0010, 8'hFF, "R3");
        step(1'b0, 4'b1010, 8'h77, "R6");
        step(1'b0, 4'b0010, 8'hEE, "R3");
        step(1'b0, 4'b1011, 8'h19, "R6");

        // R7 segment alongside a byte load
        step(1'b0, 4'b0101, 8'h4E, "R7");
        step(1'b0, 4'b1100, 8'hB2, "R7");

        // R8 idle hold over several cycles
        for (int k = 0; k < 4; k++) step(1'b0, 4'b0000, 8'(k * 53 + 7), "R8");

        // R10 reset beats every strobe
        step(1'b0, 4'b0111, 8'hDD, "R4");
        step(1'b1, 4'b1111, 8'h99, "R10");
        step(1'b0, 4'b0000, 8'h42, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule